// File: doc/BRIEF.md
# Multi-source acquisition trigger unit

This block decides when a four-channel sampling engine starts recording. It watches three kinds of source. The first is an external trigger pin, whose edge is detected after synchronization. The second is a threshold crossing on one chosen ADC channel. The third is a strobe written by software. A hardware enable governs the pin and the channel comparator. Software strobes have their own enable. A trigger is accepted only while the acquisition controller reports that it is armed.

An accepted trigger starts a programmable countdown measured in sample-clock cycles. When the countdown ends, the trigger is emitted on the next sample that is actually stored. With decimation active this keeps the trigger aligned with recorded data. A registered interrupt strobe follows each trigger pulse one cycle later.

Top module: `acq_trig_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, `trig_out` and `trig_irq` are 0.
- R2: With `cfg_hw_en`=1, `cfg_hw_src`=0 (pin) and `cfg_ext_fall`=0, a 0-to-1 change of `ext_trig_in` qualifies a trigger in the cycle that follows the second clock edge sampling the new level. A 1-to-0 change does not.
- R3: With `cfg_ext_fall`=1, a 1-to-0 change of the pin qualifies with the same latency as R2, and a 0-to-1 change does not.
- R4: With `cfg_hw_src`=1 (channel) and `cfg_int_neg`=0, a valid sample qualifies when the previous valid sample of the selected channel is below `cfg_threshold` and the current one is at or above it. Values are signed.
- R5: With `cfg_int_neg`=1, a valid sample qualifies when the previous sample is above the threshold and the current one is at or below it.
- R6: `cfg_int_chan` value k selects the channel found at bits [k*16 +: 16] of `smp_data`, where k=0 is channel 1. Crossings on the other channels have no effect.
- R7: With `cfg_hw_en`=0, neither pin edges nor channel crossings produce a trigger.
- R8: A `sw_trig_stb` cycle qualifies a trigger only when `cfg_sw_en`=1, whatever the value of `cfg_hw_en`.
- R9: A qualification with `cfg_delay`=D produces `trig_out` D cycles later. D=0 gives the same cycle. A new qualification during a countdown restarts it.
- R10: No source qualifies while `armed`=0.
- R11: `trig_out` is high only in cycles with `smp_store`=1. A trigger that falls due while `smp_store`=0 is held and is emitted at the next stored sample.
- R12: `trig_irq` is high exactly in the cycle after each `trig_out` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_trig_in | input | 1 | Asynchronous external trigger pin |
| smp_valid | input | 1 | A new sample set is present on `smp_data` |
| smp_store | input | 1 | The current sample is kept after decimation |
| smp_data | input | 64 | Four signed 16-bit samples; channel k+1 is at [k*16 +: 16] |
| armed | input | 1 | The acquisition controller is waiting for a trigger |
| cfg_hw_en | input | 1 | Enable for the pin and channel sources |
| cfg_hw_src | input | 1 | 0 selects the pin, 1 selects the channel comparator |
| cfg_ext_fall | input | 1 | 0 selects the rising pin edge, 1 the falling edge |
| cfg_int_neg | input | 1 | 0 selects a positive slope, 1 a negative slope |
| cfg_int_chan | input | 2 | Compared channel, 0..3 |
| cfg_threshold | input | 16 | Signed crossing level |
| cfg_sw_en | input | 1 | Enable for software strobes |
| cfg_delay | input | 16 | Cycles between qualification and trigger |
| sw_trig_stb | input | 1 | One-cycle software trigger request |
| trig_out | output | 1 | One-cycle trigger pulse |
| trig_irq | output | 1 | Trigger interrupt strobe |

## Verification
A pin change applied before clock edge k qualifies in the cycle after edge k+1. A channel crossing or a software strobe qualifies in the cycle it is presented. `trig_out` then appears D cycles after qualification, or later if `smp_store` is low, and `trig_irq` one cycle after that. The bench drives inputs just after a rising edge and samples at the falling edge. It advances its own model once per cycle, so each comparison lands in the cycle where the result is due. Directed checks measure the distance from the strobe cycle to the pulse cycle and count the pulses each scenario must produce.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;

    typedef enum logic {
        SRC_PIN  = 1'b0,
        SRC_CHAN = 1'b1
    } hw_src_e;

    typedef struct packed {
        logic pin_hit;
        logic chan_hit;
        logic sw_hit;
    } src_hits_t;

    // Threshold crossing test on sign-extended values.
    function automatic logic crossed(input logic signed [31:0] prv,
                                     input logic signed [31:0] cur,
                                     input logic signed [31:0] thr,
                                     input logic               neg);
        if (neg)
            return (prv > thr) && (cur <= thr);
        else
            return (prv < thr) && (cur >= thr);
    endfunction

endpackage

// File: rtl/acq_trig_pin_edge.sv
module acq_trig_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic falling,
    output logic hit
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[LEN-2:0], pin};
    end

    logic now_lvl, old_lvl;
    assign now_lvl = sh_q[STAGES-1];
    assign old_lvl = sh_q[STAGES];
    assign hit = falling ? (!now_lvl && old_lvl) : (now_lvl && !old_lvl);

endmodule

// File: rtl/acq_trig_level.sv
module acq_trig_level
    import acq_trig_pkg::*;
#(
    parameter  int NCH   = 4,
    parameter  int SMP_W = 16,
    localparam int CH_W  = $clog2(NCH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic [NCH*SMP_W-1:0]    smp_data,
    input  logic [CH_W-1:0]         chan,
    input  logic signed [SMP_W-1:0] thr,
    input  logic                    neg,
    output logic                    hit
);
    logic signed [SMP_W-1:0] prv_q [NCH];
    logic signed [SMP_W-1:0] cur_s [NCH];
    logic                    seen_q;

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        assign cur_s[k] = smp_data[k*SMP_W +: SMP_W];
        always_ff @(posedge clk) begin
            if (rst)            prv_q[k] <= '0;
            else if (smp_valid) prv_q[k] <= cur_s[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            seen_q <= 1'b0;
        else if (smp_valid) seen_q <= 1'b1;
    end

    logic signed [SMP_W-1:0] cur_sel, prv_sel;
    assign cur_sel = cur_s[chan];
    assign prv_sel = prv_q[chan];

    assign hit = smp_valid && seen_q && crossed(prv_sel, cur_sel, thr, neg);

endmodule

// File: rtl/acq_trig_delay.sv
module acq_trig_delay #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             qual,
    input  logic [DLY_W-1:0] delay,
    input  logic             store,
    output logic             fire
);
    logic [DLY_W-1:0] cnt_q;
    logic             pend_q;
    logic             load, due;

    assign load = qual && (delay != '0);
    assign due  = (qual && (delay == '0)) || (cnt_q == DLY_W'(1)) || pend_q;
    assign fire = due && store;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            pend_q <= due && !store;
            if (load)             cnt_q <= delay;
            else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end

    // R9: countdown steps by one while not reloaded
    a_r9_countdown_step: assert property (@(posedge clk) disable iff (rst)
        (cnt_q > DLY_W'(1) && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R11: pulses land only on stored samples
    a_r11_store_aligned: assert property (@(posedge clk) disable iff (rst)
        fire |-> store);

endmodule

// File: rtl/acq_trig_unit.sv
module acq_trig_unit
    import acq_trig_pkg::*;
#(
    parameter  int NCH    = 4,
    parameter  int SMP_W  = 16,
    parameter  int DLY_W  = 16,
    parameter  int STAGES = 2,
    localparam int CH_W   = $clog2(NCH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ext_trig_in,
    input  logic                    smp_valid,
    input  logic                    smp_store,
    input  logic [NCH*SMP_W-1:0]    smp_data,
    input  logic                    armed,
    input  logic                    cfg_hw_en,
    input  logic                    cfg_hw_src,
    input  logic                    cfg_ext_fall,
    input  logic                    cfg_int_neg,
    input  logic [CH_W-1:0]         cfg_int_chan,
    input  logic signed [SMP_W-1:0] cfg_threshold,
    input  logic                    cfg_sw_en,
    input  logic [DLY_W-1:0]        cfg_delay,
    input  logic                    sw_trig_stb,
    output logic                    trig_out,
    output logic                    trig_irq
);
    src_hits_t hits;
    hw_src_e   src_sel;
    logic      hw_hit, qual;

    acq_trig_pin_edge #(.STAGES(STAGES)) u_pin (
        .clk     (clk),
        .rst     (rst),
        .pin     (ext_trig_in),
        .falling (cfg_ext_fall),
        .hit     (hits.pin_hit)
    );

    acq_trig_level #(.NCH(NCH), .SMP_W(SMP_W)) u_level (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .chan      (cfg_int_chan),
        .thr       (cfg_threshold),
        .neg       (cfg_int_neg),
        .hit       (hits.chan_hit)
    );

    assign hits.sw_hit = sw_trig_stb && cfg_sw_en;
    assign src_sel     = hw_src_e'(cfg_hw_src);
    assign hw_hit      = (src_sel == SRC_CHAN) ? hits.chan_hit : hits.pin_hit;
    assign qual        = armed && ((cfg_hw_en && hw_hit) || hits.sw_hit);

    acq_trig_delay #(.DLY_W(DLY_W)) u_delay (
        .clk   (clk),
        .rst   (rst),
        .qual  (qual),
        .delay (cfg_delay),
        .store (smp_store),
        .fire  (trig_out)
    );

    always_ff @(posedge clk) begin
        if (rst) trig_irq <= 1'b0;
        else     trig_irq <= trig_out;
    end

    // R12: interrupt strobe tracks the trigger pulse one cycle later
    a_r12_irq_follows: assert property (@(posedge clk) disable iff (rst)
        trig_out |=> trig_irq);
    a_r12_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        !trig_out |=> !trig_irq);

    // R9: zero delay fires in the qualification cycle on a stored sample
    a_r9_zero_delay: assert property (@(posedge clk) disable iff (rst)
        (qual && cfg_delay == '0 && smp_store) |-> trig_out);

endmodule

// File: tb/acq_trig_unit_bench.sv
module acq_trig_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_trig_in = 1'b0;
    logic        smp_valid = 1'b1;
    logic        smp_store = 1'b1;
    logic [63:0] smp_data = '0;
    logic        armed = 1'b0;
    logic        cfg_hw_en = 1'b0;
    logic        cfg_hw_src = 1'b0;
    logic        cfg_ext_fall = 1'b0;
    logic        cfg_int_neg = 1'b0;
    logic [1:0]  cfg_int_chan = '0;
    logic signed [15:0] cfg_threshold = 16'sd100;
    logic        cfg_sw_en = 1'b0;
    logic [15:0] cfg_delay = '0;
    logic        sw_trig_stb = 1'b0;
    logic        trig_out, trig_irq;

    always #2 clk = ~clk;

    acq_trig_unit u_acq_trig_unit (
        .clk(clk), .rst(rst), .ext_trig_in(ext_trig_in),
        .smp_valid(smp_valid), .smp_store(smp_store), .smp_data(smp_data),
        .armed(armed), .cfg_hw_en(cfg_hw_en), .cfg_hw_src(cfg_hw_src),
        .cfg_ext_fall(cfg_ext_fall), .cfg_int_neg(cfg_int_neg),
        .cfg_int_chan(cfg_int_chan), .cfg_threshold(cfg_threshold),
        .cfg_sw_en(cfg_sw_en), .cfg_delay(cfg_delay),
        .sw_trig_stb(sw_trig_stb), .trig_out(trig_out), .trig_irq(trig_irq)
    );

    int    checks = 0, failures = 0, cyc = 0, pulses = 0, last_pulse = -1;
    string cur_req = "R1";

    task automatic chk(input string req, input int act, input int exp_v, input string what);
        checks++;
        if (act != exp_v) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp_v, cyc);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_smp(input int a, input int b, input int c, input int d);
        smp_data = {16'(d), 16'(c), 16'(b), 16'(a)};
    endtask

    // Behavioural reference model, advanced at each falling edge
    int m_sync[3];
    int m_prev[4];
    bit m_seen, m_pend, m_irq;
    int m_cnt;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (rst) begin
            m_sync = '{0, 0, 0};
            m_prev = '{0, 0, 0, 0};
            m_seen = 0; m_pend = 0; m_irq = 0; m_cnt = 0;
        end else begin
            bit pin_h, ch_h, qual, due, exp_out;
            int cur, thr;
            pin_h = cfg_ext_fall ? (m_sync[1] == 0 && m_sync[2] == 1)
                                 : (m_sync[1] == 1 && m_sync[2] == 0);
            cur = $signed(smp_data[cfg_int_chan*16 +: 16]);
            thr = cfg_threshold;
            ch_h = smp_valid && m_seen &&
                   (cfg_int_neg ? (m_prev[cfg_int_chan] > thr && cur <= thr)
                                : (m_prev[cfg_int_chan] < thr && cur >= thr));
            qual = armed && ((cfg_hw_en && (cfg_hw_src ? ch_h : pin_h)) ||
                             (cfg_sw_en && sw_trig_stb));
            due = (qual && cfg_delay == 0) || m_cnt == 1 || m_pend;
            exp_out = due && smp_store;
            chk(cur_req, int'(trig_out), int'(exp_out), "trig_out vs model");
            chk("R12", int'(trig_irq), int'(m_irq), "trig_irq vs model");
            if (trig_out) begin pulses++; last_pulse = cyc; end
            m_irq = exp_out;
            m_pend = due && !smp_store;
            if (qual && cfg_delay != 0) m_cnt = cfg_delay;
            else if (m_cnt > 0)         m_cnt--;
            if (smp_valid) begin
                for (int k = 0; k < 4; k++) m_prev[k] = $signed(smp_data[k*16 +: 16]);
                m_seen = 1;
            end
            m_sync[2] = m_sync[1]; m_sync[1] = m_sync[0]; m_sync[0] = ext_trig_in;
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int p0, sc;
        step(3);
        @(negedge clk);
        chk("R1", int'(trig_out), 0, "trig_out in reset");
        step(0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", int'(trig_out), 0, "trig_out after reset");
        chk("R1", int'(trig_irq), 0, "trig_irq after reset");
        step(1);

        // R2: rising pin edge
        cur_req = "R2"; armed = 1; cfg_hw_en = 1; cfg_hw_src = 0; cfg_ext_fall = 0;
        step(4); p0 = pulses;
        ext_trig_in = 1; sc = cyc;
        step(6);
        chk("R2", pulses - p0, 1, "pulses on rising edge");
        chk("R2", last_pulse - sc, 2, "pin latency");
        p0 = pulses; ext_trig_in = 0; step(6);
        chk("R2", pulses - p0, 0, "pulses on falling edge in rising mode");

        // R3: falling pin edge
        cur_req = "R3"; cfg_ext_fall = 1; ext_trig_in = 1; step(6);
        p0 = pulses; ext_trig_in = 0; sc = cyc; step(6);
        chk("R3", pulses - p0, 1, "pulses on falling edge");
        chk("R3", last_pulse - sc, 2, "falling latency");
        p0 = pulses; ext_trig_in = 1; step(6);
        chk("R3", pulses - p0, 0, "pulses on rising edge in falling mode");

        // R4 / R6: positive slope on channel 3, noise on others
        cur_req = "R4"; cfg_hw_src = 1; cfg_int_neg = 0; cfg_int_chan = 2;
        set_smp(0, 0, 50, 0); step(2); p0 = pulses;
        set_smp(500, -300, 150, 500); step(1);
        set_smp(0, 300, 200, 0); step(1);
        set_smp(500, -300, 50, 500); step(1);
        set_smp(0, 300, 100, 0); step(1);
        set_smp(500, -300, 99, 500); step(1);
        chk("R4", pulses - p0, 2, "positive crossings on channel 3");

        // R5: negative slope
        cur_req = "R5"; cfg_int_neg = 1;
        set_smp(0, 0, 150, 0); step(1); p0 = pulses;
        set_smp(0, 0, 50, 0); step(1);
        set_smp(0, 0, 100, 0); step(1);
        set_smp(0, 0, 200, 0); step(1);
        set_smp(0, 0, 100, 0); step(1);
        set_smp(0, 0, -5, 0); step(1);
        chk("R5", pulses - p0, 2, "negative crossings");

        // R6: channel 1 selected, only channel 4 crosses
        cur_req = "R6"; cfg_int_neg = 0; cfg_int_chan = 0;
        set_smp(0, 0, 0, 0); step(1); p0 = pulses;
        set_smp(0, 0, 0, 900); step(1);
        set_smp(0, 0, 0, 0); step(1);
        set_smp(0, 0, 0, 900); step(1);
        chk("R6", pulses - p0, 0, "crossings on unselected channel");
        set_smp(400, 0, 0, 0); step(1);
        chk("R6", pulses - p0, 1, "crossing on selected channel 1");

        // R7: hardware disabled
        cur_req = "R7"; cfg_hw_en = 0; set_smp(0, 0, 0, 0); step(1); p0 = pulses;
        set_smp(400, 0, 0, 0); step(1);
        cfg_hw_src = 0; cfg_ext_fall = 0; ext_trig_in = 0; step(4);
        ext_trig_in = 1; step(5);
        chk("R7", pulses - p0, 0, "hardware sources while disabled");

        // R8: software strobe
        cur_req = "R8"; p0 = pulses;
        sw_trig_stb = 1; step(1); sw_trig_stb = 0; step(2);
        chk("R8", pulses - p0, 0, "strobe with software disabled");
        cfg_sw_en = 1; sw_trig_stb = 1; @(negedge clk);
        chk("R8", int'(trig_out), 1, "strobe with software enabled");
        step(1); sw_trig_stb = 0; step(2);
        chk("R8", pulses - p0, 1, "software pulses");

        // R10: not armed
        cur_req = "R10"; armed = 0; p0 = pulses;
        sw_trig_stb = 1; step(1); sw_trig_stb = 0; step(3);
        chk("R10", pulses - p0, 0, "strobe while not armed");
        armed = 1;

        // R9: delay and reload
        cur_req = "R9"; cfg_delay = 5; p0 = pulses;
        sw_trig_stb = 1; sc = cyc; step(1); sw_trig_stb = 0; step(8);
        chk("R9", last_pulse - sc, 5, "delay of 5");
        p0 = pulses;
        sw_trig_stb = 1; step(1); sw_trig_stb = 0; step(2);
        sw_trig_stb = 1; sc = cyc; step(1); sw_trig_stb = 0; step(8);
        chk("R9", pulses - p0, 1, "single pulse after reload");
        chk("R9", last_pulse - sc, 5, "delay measured from reload");

        // R11: alignment to stored samples
        cur_req = "R11"; cfg_delay = 2; smp_store = 0; p0 = pulses;
        sw_trig_stb = 1; step(1); sw_trig_stb = 0; step(5);
        chk("R11", pulses - p0, 0, "no pulse without stored sample");
        smp_store = 1; sc = cyc; step(3);
        chk("R11", pulses - p0, 1, "held pulse emitted");
        chk("R11", last_pulse, sc, "held pulse cycle");

        step(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule